// File: doc/BRIEF.md
# Endpoint Packet-Size Table and Buffer Allocator

This block keeps the maximum packet size of every physical endpoint of a USB device controller and lays their buffers out in a shared endpoint RAM. Software uses a small register bus. It first writes an endpoint number into an index register. It then writes or reads the packet size of that endpoint through a size window. Every write to the size window starts a walk over all endpoints. The walk runs one endpoint per clock, in ascending order. It gives each endpoint a word-aligned base address and decides whether that endpoint is realized.

The walk is run by a three-state machine:
- `S_IDLE`: no walk is running. A size write moves the machine to `S_WALK`.
- `S_WALK`: the machine processes the endpoint at the pointer and advances the pointer. After the last endpoint it moves to `S_DONE`. A size write here restarts the walk at endpoint 0.
- `S_DONE`: this state lasts one cycle. It raises the completion pulse and returns to `S_IDLE`. A size write in this cycle sends the machine back to `S_WALK` and suppresses the pulse.

The completion pulse sets a sticky status bit. That bit, gated by an enable bit, drives the interrupt. The block also exports a qualifier per endpoint that is true only when the endpoint is both realized and enabled. The controller uses this qualifier to decide whether an endpoint answers transactions.

Top module: `ep_size_alloc`

## Requirements
- R1: Address 0 is the index register. A write stores bits 4:0 as the selected endpoint and ignores bits 31:5. A read of address 0 returns 0.
- R2: Address 1 is the size window. A write stores bits 9:0 into the entry of the selected endpoint and ignores bits 31:10. A read returns that entry in bits 9:0, with bits 31:10 reading as zero.
- R3: After reset:
  - endpoints 0 and 1 hold size 8 and all other endpoints hold 0;
  - endpoint 0 has base 0 and endpoint 1 has base 2;
  - only endpoints 0 and 1 are realized;
  - busy, irq and every status and enable bit are 0.
- R4: A size write sampled at clock edge k makes busy high after edge k. Busy stays high until edge k+33. At that edge busy falls and the completion status bit sets.
- R5: The walk visits endpoints 0 to 31 in order. The base of each endpoint is a word address: the sum over all lower endpoints of ceil(size/4).
- R6: An endpoint is realized when its size is nonzero and its buffer ends within RAM_WORDS words. The active output of an endpoint equals realized AND its enable input.
- R7: Suppose an endpoint's buffer would end beyond RAM_WORDS. Then that endpoint and every later endpoint are unrealized with base 0, and the overflow status bit (status bit 1) sets at the end of the walk.
- R8: A size write while busy stores the value and restarts the walk from endpoint 0. Only one completion is raised, at the end of the last walk.
- R9: Address 2 is the status register: bit 0 is completion, bit 1 is overflow and bit 2 is busy. A write of one to bit 0 or bit 1 at address 4 clears the matching status bit. When a set and a clear of the same bit fall in the same cycle, the bit stays set.
- R10: Address 3 bit 0 is the interrupt enable, which can be read back. The irq output equals completion status AND interrupt enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| ep_enable | input | 32 | Enable bit for each endpoint |
| ep_realized | output | 32 | Realized flag for each endpoint |
| ep_active | output | 32 | Realized AND enabled, for each endpoint |
| ep_base | output | 352 | 11-bit word base address for each endpoint; endpoint i at bits [11i+10:11i] |
| busy | output | 1 | A walk is in progress |
| irq | output | 1 | Completion interrupt |

## Verification
Some properties are checked by the assertions on every cycle:
- A size write lands in the entry named by the index.
- A walk that is not interrupted advances its pointer by one each cycle.
- A completion that coincides with a clear leaves the status bit set.
- Whenever the machine is idle, every realized endpoint fits inside the RAM.

Other behaviours need the bench's scenarios:
- The exact base addresses produced by a sequence of writes.
- The 33-cycle busy window.
- The cut-off point after an overflow.
- The single interrupt after a restarted walk.

// File: rtl/ep_alloc_pkg.sv
package ep_alloc_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WALK = 2'd1,
        S_DONE = 2'd2
    } walk_state_t;

    localparam logic [2:0] REG_INDEX  = 3'd0;
    localparam logic [2:0] REG_SIZE   = 3'd1;
    localparam logic [2:0] REG_STATUS = 3'd2;
    localparam logic [2:0] REG_IRQEN  = 3'd3;
    localparam logic [2:0] REG_CLEAR  = 3'd4;
endpackage

// File: rtl/ep_size_regs.sv
module ep_size_regs
    import ep_alloc_pkg::*;
#(
    parameter int NUM_EP       = 32,
    parameter int MPS_W        = 10,
    parameter int RST_CTRL_MPS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [2:0]              bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic [NUM_EP*MPS_W-1:0] mps_flat,
    output logic                    start,
    input  logic                    busy,
    input  logic                    done_pulse,
    input  logic                    ovf_pulse,
    output logic                    irq
);
    localparam int IDX_W = $clog2(NUM_EP);

    logic [IDX_W-1:0] idx_q;
    logic [MPS_W-1:0] mps_q [NUM_EP];
    logic             done_q, ovf_q, ie_q;
    logic             wr_index, wr_size, wr_irqen, wr_clear;
    logic             unused_hi;

    assign wr_index  = bus_sel && bus_wr && (bus_addr == REG_INDEX);
    assign wr_size   = bus_sel && bus_wr && (bus_addr == REG_SIZE);
    assign wr_irqen  = bus_sel && bus_wr && (bus_addr == REG_IRQEN);
    assign wr_clear  = bus_sel && bus_wr && (bus_addr == REG_CLEAR);
    assign start     = wr_size;
    assign unused_hi = ^bus_wdata[31:MPS_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        idx_q <= '0;
        else if (wr_index) idx_q <= bus_wdata[IDX_W-1:0];
    end

    for (genvar i = 0; i < NUM_EP; i++) begin : g_entry
        localparam logic [MPS_W-1:0] RST_VAL = (i < 2) ? MPS_W'(RST_CTRL_MPS) : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   mps_q[i] <= RST_VAL;
            else if (wr_size && idx_q == IDX_W'(i))       mps_q[i] <= bus_wdata[MPS_W-1:0];
        end
        assign mps_flat[i*MPS_W +: MPS_W] = mps_q[i];
    end

    // status bits: a set in the same cycle as a clear wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ovf_q  <= 1'b0;
            ie_q   <= 1'b0;
        end else begin
            if (done_pulse)                     done_q <= 1'b1;
            else if (wr_clear && bus_wdata[0])  done_q <= 1'b0;
            if (ovf_pulse)                      ovf_q  <= 1'b1;
            else if (wr_clear && bus_wdata[1])  ovf_q  <= 1'b0;
            if (wr_irqen)                       ie_q   <= bus_wdata[0];
        end
    end

    assign irq = done_q && ie_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_SIZE:   bus_rdata = 32'(mps_q[idx_q]);
            REG_STATUS: bus_rdata = {29'd0, busy, ovf_q, done_q};
            REG_IRQEN:  bus_rdata = {31'd0, ie_q};
            default:    bus_rdata = '0;
        endcase
    end

    // R2: the written size lands in the entry selected by the index
    assert_size_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_size |=> (mps_q[$past(idx_q)] == $past(bus_wdata[MPS_W-1:0])));

    // R9: a completion that meets a clear leaves the bit set
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> done_q);

    // R9: a clear with no completion in the same cycle empties the bit
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clear && bus_wdata[0] && !done_pulse) |=> !done_q);
endmodule

// File: rtl/ep_alloc_walker.sv
module ep_alloc_walker
    import ep_alloc_pkg::*;
#(
    parameter int NUM_EP       = 32,
    parameter int MPS_W        = 10,
    parameter int RAM_WORDS    = 1024,
    parameter int ADDR_W       = 11,
    parameter int RST_CTRL_MPS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [NUM_EP*MPS_W-1:0]  mps_flat,
    output logic                     busy,
    output logic                     done_pulse,
    output logic                     ovf_pulse,
    output logic [NUM_EP*ADDR_W-1:0] base_flat,
    output logic [NUM_EP-1:0]        realized
);
    localparam int IDX_W     = $clog2(NUM_EP);
    localparam int SUM_W     = ADDR_W + MPS_W;
    localparam int RST_WORDS = (RST_CTRL_MPS + 3) / 4;
    localparam logic [IDX_W-1:0] LAST    = IDX_W'(NUM_EP - 1);
    localparam logic [SUM_W-1:0] RAM_LIM = SUM_W'(RAM_WORDS);

    walk_state_t      state_q, state_d;
    logic [IDX_W-1:0] ptr_q;
    logic [SUM_W-1:0] sum_q;
    logic             ovf_run_q;
    logic [ADDR_W-1:0] base_q [NUM_EP];

    logic [MPS_W-1:0] cur_mps;
    logic [SUM_W-1:0] cur_words, cur_end;
    logic             cur_fits;

    function automatic logic [SUM_W-1:0] words_of(input logic [MPS_W-1:0] sz);
        logic [SUM_W-1:0] tmp;
        tmp = SUM_W'(sz) + SUM_W'(3);
        return tmp >> 2;
    endfunction

    assign cur_mps   = mps_flat[ptr_q*MPS_W +: MPS_W];
    assign cur_words = words_of(cur_mps);
    assign cur_end   = sum_q + cur_words;
    assign cur_fits  = !ovf_run_q && (cur_end <= RAM_LIM);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = start ? S_WALK : S_IDLE;
            S_WALK:  state_d = start ? S_WALK : ((ptr_q == LAST) ? S_DONE : S_WALK);
            S_DONE:  state_d = start ? S_WALK : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        busy       = (state_q != S_IDLE);
        done_pulse = (state_q == S_DONE) && !start;
        ovf_pulse  = done_pulse && ovf_run_q;
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            sum_q     <= '0;
            ovf_run_q <= 1'b0;
            for (int i = 0; i < NUM_EP; i++) begin
                base_q[i]   <= (i == 0) ? '0 : ((i == 1) ? ADDR_W'(RST_WORDS) : ADDR_W'(2 * RST_WORDS));
                realized[i] <= (i < 2) && (RST_CTRL_MPS != 0);
            end
        end else if (start) begin
            ptr_q     <= '0;
            sum_q     <= '0;
            ovf_run_q <= 1'b0;
        end else if (state_q == S_WALK) begin
            ptr_q <= ptr_q + IDX_W'(1);
            if (cur_fits) begin
                base_q[ptr_q]   <= sum_q[ADDR_W-1:0];
                realized[ptr_q] <= (cur_mps != '0);
                sum_q           <= cur_end;
            end else begin
                base_q[ptr_q]   <= '0;
                realized[ptr_q] <= 1'b0;
                ovf_run_q       <= 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NUM_EP; i++) begin : g_out
        assign base_flat[i*ADDR_W +: ADDR_W] = base_q[i];

        // R6/R7: once settled, every realized buffer ends inside the RAM
        assert_fits_ram_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!busy && realized[i]) |->
                ((SUM_W'(base_q[i]) + words_of(mps_flat[i*MPS_W +: MPS_W])) <= RAM_LIM));
    end

    // R5: an uninterrupted walk advances one endpoint per clock
    assert_walk_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WALK && !start && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + IDX_W'(1)));

    // R8: a size write always lands the machine at endpoint 0 of a fresh walk
    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == S_WALK && ptr_q == '0 && !done_pulse));
endmodule

// File: rtl/ep_size_alloc.sv
module ep_size_alloc #(
    parameter int NUM_EP       = 32,
    parameter int MPS_W        = 10,
    parameter int RAM_WORDS    = 1024,
    parameter int RST_CTRL_MPS = 8,
    localparam int ADDR_W      = $clog2(RAM_WORDS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [2:0]               bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [NUM_EP-1:0]        ep_enable,
    output logic [NUM_EP-1:0]        ep_realized,
    output logic [NUM_EP-1:0]        ep_active,
    output logic [NUM_EP*ADDR_W-1:0] ep_base,
    output logic                     busy,
    output logic                     irq
);
    logic [NUM_EP*MPS_W-1:0] mps_flat;
    logic start, done_pulse, ovf_pulse;

    ep_size_regs #(
        .NUM_EP(NUM_EP), .MPS_W(MPS_W), .RST_CTRL_MPS(RST_CTRL_MPS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mps_flat(mps_flat), .start(start), .busy(busy),
        .done_pulse(done_pulse), .ovf_pulse(ovf_pulse), .irq(irq)
    );

    ep_alloc_walker #(
        .NUM_EP(NUM_EP), .MPS_W(MPS_W), .RAM_WORDS(RAM_WORDS),
        .ADDR_W(ADDR_W), .RST_CTRL_MPS(RST_CTRL_MPS)
    ) u_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .mps_flat(mps_flat),
        .busy(busy), .done_pulse(done_pulse), .ovf_pulse(ovf_pulse),
        .base_flat(ep_base), .realized(ep_realized)
    );

    assign ep_active = ep_realized & ep_enable;
endmodule

// File: tb/ep_size_alloc_bench.sv
module ep_size_alloc_bench;
    localparam int NEP = 32;
    localparam int AW  = 11;
    localparam int RAMW = 1024;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [NEP-1:0] ep_enable = '0, ep_realized, ep_active;
    logic [NEP*AW-1:0] ep_base;
    logic busy, irq;

    int checks = 0, failures = 0, irq_rises = 0;
    logic irq_prev = 1'b0;
    int model_mps [NEP];
    int exp_base [NEP];
    logic [NEP-1:0] exp_real;
    logic exp_ovf;
    logic [31:0] rd;

    localparam logic [14:0] VEC [6] = '{
        {5'd2, 10'd64}, {5'd3, 10'd10}, {5'd5, 10'd1},
        {5'd1, 10'd0}, {5'd31, 10'd1023}, {5'd0, 10'd1020}
    };

    always #2 clk = ~clk;

    ep_size_alloc u_ep_size_alloc (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ep_enable(ep_enable), .ep_realized(ep_realized), .ep_active(ep_active),
        .ep_base(ep_base), .busy(busy), .irq(irq)
    );

    always @(posedge clk) begin
        irq_prev <= irq;
        if (irq && !irq_prev) irq_rises <= irq_rises + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 100 && busy; n++) @(negedge clk);
    endtask

    task automatic set_size(input int ep, input int sz);
        bus_write(3'd0, 32'(ep));
        bus_write(3'd1, 32'(sz));
        model_mps[ep] = sz & 32'h3FF;
    endtask

    function automatic void build_model();
        int sum = 0;
        exp_ovf = 1'b0;
        for (int i = 0; i < NEP; i++) begin
            int w = (model_mps[i] + 3) / 4;
            if (!exp_ovf && sum + w <= RAMW) begin
                exp_base[i] = sum; exp_real[i] = (model_mps[i] != 0); sum += w;
            end else begin
                exp_ovf = 1'b1; exp_base[i] = 0; exp_real[i] = 1'b0;
            end
        end
    endfunction

    task automatic check_alloc(input string req);
        int bad = -1;
        build_model();
        for (int i = 0; i < NEP; i++)
            if (bad < 0 && (32'(ep_base[i*AW +: AW]) != 32'(exp_base[i]) || ep_realized[i] !== exp_real[i]))
                bad = i;
        checks++;
        if (bad >= 0) begin
            failures++;
            $display("FAIL %s ep%0d actual base=%0d real=%0b expected base=%0d real=%0b", req, bad,
                     ep_base[bad*AW +: AW], ep_realized[bad], exp_base[bad], exp_real[bad]);
        end
    endtask

    initial begin
        repeat (500_000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < NEP; i++) model_mps[i] = (i < 2) ? 8 : 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3 reset state
        check("R3 busy", 32'(busy), 0);
        check("R3 irq", 32'(irq), 0);
        bus_read(3'd2, rd); check("R3 status", rd, 0);
        bus_read(3'd3, rd); check("R3 irq enable", rd, 0);
        bus_read(3'd1, rd); check("R3 size ep0", rd, 8);
        bus_write(3'd0, 1); bus_read(3'd1, rd); check("R3 size ep1", rd, 8);
        bus_write(3'd0, 2); bus_read(3'd1, rd); check("R3 size ep2", rd, 0);
        check_alloc("R3 reset bases");
        bus_read(3'd0, rd); check("R1 index reads zero", rd, 0);

        // R4 busy window: write at edge k; busy falls and done sets at edge k+33
        bus_write(3'd1, 64); model_mps[2] = 64;
        check("R4 busy after write", 32'(busy), 1);
        repeat (32) @(negedge clk);
        check("R4 busy at k+32", 32'(busy), 1);
        @(negedge clk);
        check("R4 busy at k+33", 32'(busy), 0);
        bus_read(3'd2, rd); check("R4 done set", rd, 1);
        check_alloc("R5 bases after one write");
        bus_write(3'd4, 3);
        bus_read(3'd2, rd); check("R9 clear", rd, 0);

        // R5/R2 vector table
        foreach (VEC[v]) begin
            set_size(int'(VEC[v][14:10]), int'(VEC[v][9:0]));
            wait_idle();
            check_alloc("R5 table bases");
            bus_read(3'd1, rd); check("R2 table readback", rd, 32'(VEC[v][9:0]));
        end

        // R2 upper bits ignored
        set_size(7, 32'hFFFF_FFFF); wait_idle();
        bus_read(3'd1, rd); check("R2 upper bits dropped", rd, 32'h3FF);
        check_alloc("R5 after ep7 write");

        // R7 overflow
        bus_write(3'd4, 3);
        set_size(8, 1023); wait_idle();
        check_alloc("R7 overflow cut-off");
        check("R7 model overflows", 32'(exp_ovf), 1);
        bus_read(3'd2, rd); check("R7 overflow status", rd, 3);
        bus_write(3'd4, 2);
        bus_read(3'd2, rd); check("R9 clear overflow only", rd, 1);
        set_size(8, 0); wait_idle();
        check_alloc("R7 recovery");
        bus_read(3'd2, rd); check("R7 no overflow", rd, 1);

        // R6 active qualifier
        ep_enable = 32'hAAAA_AAAA;
        #1 check("R6 active", ep_active, exp_real & 32'hAAAA_AAAA);
        ep_enable = '1;
        #1 check("R6 active all enabled", ep_active, exp_real);

        // R10 irq gating
        check("R10 irq off when disabled", 32'(irq), 0);
        bus_write(3'd3, 1);
        check("R10 irq on", 32'(irq), 1);
        bus_read(3'd3, rd); check("R10 enable readback", rd, 1);
        bus_write(3'd4, 1);
        check("R10 irq after clear", 32'(irq), 0);

        // R9 set wins over same-cycle clear
        bus_write(3'd1, 20); model_mps[8] = 20;
        repeat (31) @(negedge clk);
        bus_write(3'd4, 1);
        bus_read(3'd2, rd); check("R9 set wins", rd, 1);
        check("R9 irq after set wins", 32'(irq), 1);
        bus_write(3'd4, 1);

        // R8 restart
        @(negedge clk); irq_rises = 0;
        bus_write(3'd0, 3);
        bus_write(3'd1, 40);
        repeat (4) @(negedge clk);
        bus_write(3'd1, 12); model_mps[3] = 12;
        check("R8 busy during restart", 32'(busy), 1);
        wait_idle();
        repeat (10) @(negedge clk);
        check("R8 single completion", 32'(irq_rises), 1);
        check_alloc("R8 bases after restart");
        bus_read(3'd1, rd); check("R8 last value kept", rd, 12);

        // R1 index upper bits ignored
        bus_write(3'd0, 32'hFFFF_FFE3);
        bus_read(3'd1, rd); check("R1 index low bits", rd, 12);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule